// File: doc/BRIEF.md
# Master-Clock to Frame-Rate Ratio Detector

This block measures how many master-clock cycles fit into one period of the left/right frame clock. It then snaps that count to one of seven supported oversampling ratios: 128, 192, 256, 384, 512, 768 or 1152 cycles per frame. The frame clock arrives asynchronously. It passes through a two-flop synchroniser, and each period is measured from one synchronised rising edge to the next.

The block reports four things: the classified ratio as a 3-bit code, a flag saying that the code is confirmed, and a flag that selects the reduced-passband interpolation filter for the two lowest ratios. It also raises an instability flag when the confirmed ratio keeps changing, so that power-sequencing logic can hold the converter in standby until the clocks settle. Jitter or phase wander that stays inside the tolerance window never changes the classification.

Top module: `mclk_ratio_det`

## Requirements
- R1: After reset the ratio code is 2 (256 cycles), and the valid, narrow-filter and unstable flags are all 0.
- R2: The ratio codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 and 6=1152 cycles. A period of N cycles matches a ratio when |N - nominal| < TOL, where TOL defaults to 32. Nominal±31 therefore matches, and nominal±32 does not.
- R3: A measured period that matches no ratio (for example 160 or 288 cycles) clears the valid flag and leaves the ratio code unchanged.
- R4: The first rising edge after reset or after a lost frame clock only starts a measurement. The code is loaded, and valid is set, only when two consecutive measured periods give the same ratio. A single period of another ratio clears valid.
- R5: The narrow-filter flag is 1 when the confirmed code is 0 or 1, and 0 for codes 2 to 6.
- R6: If no rising edge arrives for more than 1152+TOL cycles, the frame clock is treated as absent. Valid is cleared, and the next edge only restarts measurement.
- R7: A confirmed change of the ratio code sets the unstable flag when the previous confirmed change lay at most WIN_FRAMES measured periods earlier (default 1026).
- R8: The unstable flag clears once WIN_FRAMES measured periods pass with no confirmed change.
- R9: Periods that vary from frame to frame but stay inside one ratio's window keep valid at 1 and the code steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_clk_i | input | 1 | Left/right frame clock, asynchronous |
| ratio_code_o | output | 3 | Confirmed ratio code (R2 encoding) |
| ratio_valid_o | output | 1 | Code confirmed by two matching periods |
| narrow_filt_o | output | 1 | Select reduced-passband filter |
| unstable_o | output | 1 | Ratio changed repeatedly within the window |

## Verification
The bench probes the edges of the tolerance windows at nominal±31 and ±32, and the 160-cycle gap between the two lowest windows. A design with an off-by-one window would lock on a count it should reject, or drop a count it should accept. The bench checks valid after exactly one and after exactly two matching periods, and drops the frame clock for longer than the timeout. A design that confirms too early, or that keeps valid through a dead clock, shows a wrong flag. It also makes ratio changes closer together than the window and then holds one ratio past it, which exposes a window counter that counts the wrong events or never clears the flag.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIOS  = 7;
  localparam int MAX_NOMINAL = 1152;
  localparam int NARROW_LAST = 1;

  typedef logic [2:0] ratio_code_t;

  localparam ratio_code_t RESET_CODE = 3'd2;

  function automatic int ratio_nominal(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction
endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;
  logic [STAGES:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/mrd_period_cnt.sv
module mrd_period_cnt #(
  parameter int CNT_W = 11,
  parameter int LIMIT = 1184
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] count_o,
  output logic             meas_vld_o,
  output logic             absent_o
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  assign absent_o = (cnt_q > LIMIT_V);
  assign cnt_en   = rise_i | ~absent_o;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (rise_i) begin
      cnt_d   = CNT_W'(1);
      armed_d = 1'b1;
    end else begin
      if (!absent_o) cnt_d = cnt_q + CNT_W'(1);
      else           armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign count_o    = cnt_q;
  assign meas_vld_o = rise_i & armed_q & ~absent_o;
endmodule

// File: rtl/mrd_classify.sv
module mrd_classify
  import mrd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 32
) (
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o,
  output ratio_code_t      code_o
);
  logic [NUM_RATIOS-1:0] in_win;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int LO = ratio_nominal(g) - TOL + 1;
    localparam int HI = ratio_nominal(g) + TOL - 1;
    assign in_win[g] = ({1'b0, count_i} >= (CNT_W+1)'(LO)) &&
                       ({1'b0, count_i} <= (CNT_W+1)'(HI));
  end

  always_comb begin
    hit_o  = 1'b0;
    code_o = RESET_CODE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (in_win[i]) begin
        hit_o  = 1'b1;
        code_o = 3'(i);
      end
    end
  end
endmodule

// File: rtl/mrd_lock_ctl.sv
module mrd_lock_ctl
  import mrd_pkg::*;
#(
  parameter int WIN_FRAMES = 1026
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        meas_vld_i,
  input  logic        hit_i,
  input  ratio_code_t meas_code_i,
  input  logic        absent_i,
  output ratio_code_t code_o,
  output logic        valid_o,
  output logic        narrow_o,
  output logic        unstable_o
);
  localparam int FW = $clog2(WIN_FRAMES + 1);
  localparam logic [FW-1:0] WIN_V = FW'(WIN_FRAMES);

  ratio_code_t   code_q, code_d, cand_q, cand_d;
  logic          valid_q, valid_d, narrow_q, narrow_d;
  logic          unst_q, unst_d, cand_ok_q, cand_ok_d;
  logic          have_q, have_d, seen_q, seen_d;
  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          confirm, change;

  assign confirm = meas_vld_i & hit_i & cand_ok_q & (cand_q == meas_code_i);
  assign change  = confirm & have_q & (meas_code_i != code_q);

  always_comb begin
    code_d    = code_q;
    cand_d    = cand_q;
    valid_d   = valid_q;
    narrow_d  = narrow_q;
    unst_d    = unst_q;
    cand_ok_d = cand_ok_q;
    have_d    = have_q;
    seen_d    = seen_q;
    fcnt_d    = fcnt_q;

    if (meas_vld_i) begin
      if (!hit_i) begin
        valid_d   = 1'b0;
        cand_ok_d = 1'b0;
      end else if (confirm) begin
        valid_d  = 1'b1;
        code_d   = meas_code_i;
        narrow_d = (meas_code_i <= 3'(NARROW_LAST));
        have_d   = 1'b1;
      end else begin
        cand_d    = meas_code_i;
        cand_ok_d = 1'b1;
        valid_d   = 1'b0;
      end
    end

    if (change) begin
      fcnt_d = '0;
    end else if (meas_vld_i && (fcnt_q < WIN_V)) begin
      fcnt_d = fcnt_q + FW'(1);
    end

    if (change) begin
      unst_d = seen_q & (fcnt_q < WIN_V);
      seen_d = 1'b1;
    end else if (fcnt_q >= WIN_V) begin
      unst_d = 1'b0;
    end

    if (absent_i) begin
      valid_d   = 1'b0;
      cand_ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q    <= RESET_CODE;
      cand_q    <= RESET_CODE;
      valid_q   <= 1'b0;
      narrow_q  <= 1'b0;
      unst_q    <= 1'b0;
      cand_ok_q <= 1'b0;
      have_q    <= 1'b0;
      seen_q    <= 1'b0;
      fcnt_q    <= '0;
    end else begin
      code_q    <= code_d;
      cand_q    <= cand_d;
      valid_q   <= valid_d;
      narrow_q  <= narrow_d;
      unst_q    <= unst_d;
      cand_ok_q <= cand_ok_d;
      have_q    <= have_d;
      seen_q    <= seen_d;
      fcnt_q    <= fcnt_d;
    end
  end

  assign code_o     = code_q;
  assign valid_o    = valid_q;
  assign narrow_o   = narrow_q;
  assign unstable_o = unst_q;
endmodule

// File: rtl/mclk_ratio_det.sv
module mclk_ratio_det
  import mrd_pkg::*;
#(
  parameter int TOL        = 32,
  parameter int WIN_FRAMES = 1026,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_clk_i,
  output logic [2:0] ratio_code_o,
  output logic       ratio_valid_o,
  output logic       narrow_filt_o,
  output logic       unstable_o
);
  localparam int LIMIT = MAX_NOMINAL + TOL;
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic             rise;
  logic [CNT_W-1:0] count;
  logic             meas_vld;
  logic             absent;
  logic             hit;
  ratio_code_t      meas_code;
  ratio_code_t      code;

  mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(frame_clk_i),
    .rise_o (rise)
  );

  mrd_period_cnt #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .count_o   (count),
    .meas_vld_o(meas_vld),
    .absent_o  (absent)
  );

  mrd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .count_i(count),
    .hit_o  (hit),
    .code_o (meas_code)
  );

  mrd_lock_ctl #(.WIN_FRAMES(WIN_FRAMES)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (meas_vld),
    .hit_i      (hit),
    .meas_code_i(meas_code),
    .absent_i   (absent),
    .code_o     (code),
    .valid_o    (ratio_valid_o),
    .narrow_o   (narrow_filt_o),
    .unstable_o (unstable_o)
  );

  assign ratio_code_o = code;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       meas_vld,
  input logic       hit,
  input logic       absent,
  input logic [2:0] ratio_code_o,
  input logic       ratio_valid_o,
  input logic       narrow_filt_o,
  input logic       unstable_o
);
  assert_code_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_code_o <= 3'd6);

  assert_narrow_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_filt_o == (ratio_code_o <= 3'd1));

  assert_nomatch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld && !hit) |=> (!ratio_valid_o && $stable(ratio_code_o)));

  assert_valid_after_meas_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ratio_valid_o) |-> $past(meas_vld));

  assert_code_change_confirm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_code_o) |-> (ratio_valid_o && !$past(ratio_valid_o)));

  assert_absent_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent |=> !ratio_valid_o);

  assert_unstable_on_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unstable_o) |-> !$stable(ratio_code_o));
endmodule

bind mclk_ratio_det mrd_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .meas_vld     (meas_vld),
  .hit          (hit),
  .absent       (absent),
  .ratio_code_o (ratio_code_o),
  .ratio_valid_o(ratio_valid_o),
  .narrow_filt_o(narrow_filt_o),
  .unstable_o   (unstable_o)
);

// File: tb/mclk_ratio_det_bench.sv
module mclk_ratio_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TOL        = 32;
  localparam int WIN        = 6;
  localparam int LIMIT      = 1152 + TOL;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic [2:0] code;
  logic       valid, narrow, unstable;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int cyc = 0;
  int last_rise = 0;
  bit m_armed = 0, m_cand_ok = 0, m_have = 0, m_seen = 0;
  bit m_valid = 0, m_narrow = 0, m_unst = 0;
  int m_code = 2, m_cand = 2, m_fcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_ratio_det #(.TOL(TOL), .WIN_FRAMES(WIN)) u_mclk_ratio_det (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_clk_i  (frame),
    .ratio_code_o (code),
    .ratio_valid_o(valid),
    .narrow_filt_o(narrow),
    .unstable_o   (unstable)
  );

  function automatic int nominal(input int i);
    case (i)
      0: return 128; 1: return 192; 2: return 256; 3: return 384;
      4: return 512; 5: return 768; default: return 1152;
    endcase
  endfunction

  function automatic int classify(input int n);
    for (int i = 0; i < 7; i++) begin
      int d = n - nominal(i);
      if (d < 0) d = -d;
      if (d < TOL) return i;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " code"},     int'(code),     m_code);
    check({tag, " valid"},    int'(valid),    int'(m_valid));
    check({tag, " narrow"},   int'(narrow),   int'(m_narrow));
    check({tag, " unstable"}, int'(unstable), int'(m_unst));
  endtask

  task automatic model_measure(input int gap);
    int k = classify(gap);
    bit chg = 0;
    if (k < 0) begin
      m_valid = 0; m_cand_ok = 0;
    end else if (m_cand_ok && m_cand == k) begin
      chg = m_have && (k != m_code);
      m_valid = 1; m_code = k; m_narrow = (k <= 1); m_have = 1;
    end else begin
      m_cand = k; m_cand_ok = 1; m_valid = 0;
    end
    if (chg) begin
      m_unst = m_seen && (m_fcnt < WIN);
      m_fcnt = 0; m_seen = 1;
    end else begin
      if (m_fcnt < WIN) m_fcnt++;
      if (m_fcnt >= WIN) m_unst = 0;
    end
  endtask

  task automatic model_rise(input int t);
    int gap = t - last_rise;
    last_rise = t;
    if (gap > LIMIT) begin
      m_valid = 0; m_cand_ok = 0;
    end else if (m_armed) begin
      model_measure(gap);
    end
    m_armed = 1;
  endtask

  task automatic drive_frame(input int p);
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      frame = (c < p/2);
      if (c == 0) model_rise(cyc);
      cyc++;
    end
  endtask

  task automatic run(input int p, input int n);
    for (int f = 0; f < n; f++) drive_frame(p);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      frame = 1'b0;
      cyc++;
    end
    if (cyc - last_rise > LIMIT + 10) begin
      m_valid = 0; m_cand_ok = 0; m_armed = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7345));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 code", int'(code), 2);
    check("R1 valid", int'(valid), 0);
    check("R1 narrow", int'(narrow), 0);
    check("R1 unstable", int'(unstable), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc = 0;

    // R4: one matching period is not enough, two are
    run(256, 2);
    check("R4 single period valid", int'(valid), 0);
    check_all("R4 one");
    run(256, 1);
    check("R4 two periods valid", int'(valid), 1);
    check_all("R4 two");

    // R5: low ratio selects narrow filter; first change after lock
    run(192, 3);
    check("R5 narrow at 192", int'(narrow), 1);
    check_all("R5");

    // R7: second change close to the first
    run(384, 3);
    check("R7 unstable set", int'(unstable), 1);
    check_all("R7");

    // R8: hold the ratio beyond the window
    run(384, WIN + 2);
    check("R8 unstable cleared", int'(unstable), 0);
    check_all("R8");

    // R2 window edges
    run(287, 3);  check("R2 287 code", int'(code), 2); check_all("R2 287");
    run(225, 3);  check_all("R2 225");
    run(97, 3);   check("R2 97 code", int'(code), 0); check_all("R2 97");

    // R3 counts that match nothing
    run(288, 2);  check("R3 288 valid", int'(valid), 0); check_all("R3 288");
    run(160, 2);  check("R3 160 code", int'(code), 0); check_all("R3 160");

    // R9 jitter within one window
    run(256, 3);
    for (int f = 0; f < 10; f++) begin
      drive_frame((f % 2) ? 256 + 25 : 256 - 25);
      check("R9 jitter valid", int'(valid), 1);
      check_all("R9");
    end

    // R6 frame clock absent, then resumes
    idle(1300);
    check("R6 absent valid", int'(valid), 0);
    check_all("R6 absent");
    run(512, 2);
    check("R6 rearm valid", int'(valid), 0);
    run(512, 2);
    check("R6 relock code", int'(code), 4);
    check_all("R6 relock");
    run(1152, 3);
    check("R2 1152 code", int'(code), 6);
    check_all("R2 1152");

    // random periods around the nominals, some off-window
    for (int b = 0; b < 30; b++) begin
      int idx = int'($urandom_range(6, 0));
      int off = int'($urandom_range(80, 0)) - 40;
      int n   = int'($urandom_range(4, 2));
      if (idx == 6 && b % 2 == 0) off = 0;
      run(nominal(idx) + off, n);
      check_all("R2 R3 R4 R7 R8 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule